// File: doc/BRIEF.md
# Interrupt Vector Receive Latch

This block sits between an interrupt source and a processor core. The source presents a request level and a 6-bit vector number. When the request is high and the latch is free, the block captures the vector into the first of three 64-bit data words and clears the other two. It also sets a busy flag in its status word, loads a fixed vector-trap index, raises a hard-interrupt request towards the core and pulses a wake signal for one cycle to bring a halted core out of its halt.

While the busy flag is set, further raised requests are ignored and their vectors are lost. When the source drops its request while the latch is busy, the busy flag and the hard-interrupt request both clear. The captured data and the trap index stay as they were until the next capture.

All inputs are sampled on the rising clock edge. All outputs are registered, so a change appears one cycle after the input that caused it.

Top module: `ivec_latch`

## Requirements
- R1: After reset the status word, all three data words, the trap index, the hard-interrupt request and the wake pulse are all zero.
- R2: A high request sampled while status bit 5 is 0 causes the next cycle to show status bit 5 = 1, hard-interrupt request = 1 and trap index = 0x060. All other status bits stay 0.
- R3: On such a capture, data word 0 becomes 0x7C0 OR the vector number, which places the constant 0x1F in bits 10:6 and the vector in bits 5:0. Data words 1 and 2 become 0.
- R4: A high request sampled while status bit 5 is 1 changes nothing: the status, data words, trap index and hard-interrupt request keep their values, and the presented vector is dropped.
- R5: A low request sampled while status bit 5 is 1 clears status bit 5 and the hard-interrupt request in the next cycle. The data words and the trap index are kept.
- R6: The wake output is 1 for exactly the one cycle that follows an accepted capture, and 0 in every other cycle.
- R7: A low request sampled while status bit 5 is 0 changes nothing.
- R8: After a release, a new high request is accepted again and captures the newly presented vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Request level from the interrupt source |
| vec_i | input | 6 | Vector number presented with the request |
| status_o | output | 8 | Status word; bit 5 is the busy flag |
| data0_o | output | 64 | Data word 0: tag 0x1F in bits 10:6, vector in bits 5:0 |
| data1_o | output | 64 | Data word 1, cleared on capture |
| data2_o | output | 64 | Data word 2, cleared on capture |
| trap_idx_o | output | 9 | Trap index handed to the core |
| hard_req_o | output | 1 | Hard-interrupt request to the core |
| wake_o | output | 1 | One-cycle pulse that releases a halted core |

## Verification
A busy flag that is stuck at 0 lets a second raised request overwrite data word 0 and re-pulse wake on the very next cycle. A flag stuck at 1 instead means the vector of a later raise never reaches the data word. A busy flag that clears too early or too late shows up as a one-cycle error in the hard-interrupt request after the request falls. Every step compares the complete output set one cycle after the input, so any of these faults surfaces within a single clock of the stimulus that exposes it.

// File: rtl/ivl_pkg.sv
package ivl_pkg;

    localparam int VEC_W      = 6;
    localparam int WORD_W     = 64;
    localparam int NUM_WORDS  = 3;
    localparam int STAT_W     = 8;
    localparam int BUSY_BIT   = 5;
    localparam int TRAP_W     = 9;
    localparam logic [TRAP_W-1:0] TRAP_VEC = 9'h060;
    localparam int TAG_W      = 5;
    localparam logic [TAG_W-1:0] TAG_VAL = 5'h1F;

    typedef enum logic [1:0] {
        ACT_HOLD    = 2'd0,
        ACT_ACCEPT  = 2'd1,
        ACT_RELEASE = 2'd2
    } act_e;

endpackage

// File: rtl/ivl_ctrl.sv
module ivl_ctrl
    import ivl_pkg::*;
(
    input  logic req_i,
    input  logic busy_i,
    output act_e act_o
);

    always_comb begin
        act_o = ACT_HOLD;
        if (req_i && !busy_i) begin
            act_o = ACT_ACCEPT;
        end else if (!req_i && busy_i) begin
            act_o = ACT_RELEASE;
        end
    end

endmodule

// File: rtl/ivl_fmt.sv
module ivl_fmt #(
    parameter int                 VEC_W     = 6,
    parameter int                 WORD_W    = 64,
    parameter int                 NUM_WORDS = 3,
    parameter int                 TAG_W     = 5,
    parameter logic [TAG_W-1:0]   TAG_VAL   = 5'h1F
) (
    input  logic [VEC_W-1:0]                  vec_i,
    output logic [NUM_WORDS-1:0][WORD_W-1:0]  words_o
);

    localparam int PAD_W = WORD_W - TAG_W - VEC_W;

    for (genvar gi = 0; gi < NUM_WORDS; gi++) begin : g_word
        if (gi == 0) begin : g_head
            assign words_o[gi] = {{PAD_W{1'b0}}, TAG_VAL, vec_i};
        end else begin : g_zero
            assign words_o[gi] = '0;
        end
    end

endmodule

// File: rtl/ivec_latch.sv
module ivec_latch
    import ivl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic [5:0]        vec_i,
    output logic [7:0]        status_o,
    output logic [63:0]       data0_o,
    output logic [63:0]       data1_o,
    output logic [63:0]       data2_o,
    output logic [8:0]        trap_idx_o,
    output logic              hard_req_o,
    output logic              wake_o
);

    typedef struct packed {
        logic                               busy;
        logic                               hard;
        logic                               wake;
        logic [TRAP_W-1:0]                  trap;
        logic [NUM_WORDS-1:0][WORD_W-1:0]   words;
    } st_t;

    st_t  st_d, st_q;
    act_e act;
    logic [NUM_WORDS-1:0][WORD_W-1:0] fmt_words;

    ivl_ctrl u_ctrl (
        .req_i  (req_i),
        .busy_i (st_q.busy),
        .act_o  (act)
    );

    ivl_fmt #(
        .VEC_W     (VEC_W),
        .WORD_W    (WORD_W),
        .NUM_WORDS (NUM_WORDS),
        .TAG_W     (TAG_W),
        .TAG_VAL   (TAG_VAL)
    ) u_fmt (
        .vec_i   (vec_i),
        .words_o (fmt_words)
    );

    always_comb begin
        st_d      = st_q;
        st_d.wake = 1'b0;
        case (act)
            ACT_ACCEPT: begin
                st_d.busy  = 1'b1;
                st_d.hard  = 1'b1;
                st_d.wake  = 1'b1;
                st_d.trap  = TRAP_VEC;
                st_d.words = fmt_words;
            end
            ACT_RELEASE: begin
                st_d.busy = 1'b0;
                st_d.hard = 1'b0;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar gb = 0; gb < STAT_W; gb++) begin : g_stat
        if (gb == BUSY_BIT) begin : g_busy
            assign status_o[gb] = st_q.busy;
        end else begin : g_rsvd
            assign status_o[gb] = 1'b0;
        end
    end

    assign data0_o    = st_q.words[0];
    assign data1_o    = st_q.words[1];
    assign data2_o    = st_q.words[2];
    assign trap_idx_o = st_q.trap;
    assign hard_req_o = st_q.hard;
    assign wake_o     = st_q.wake;

    AST_ACCEPT_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !status_o[BUSY_BIT]) |=> (status_o[BUSY_BIT] && hard_req_o
                                            && trap_idx_o == TRAP_VEC)); // R2
    AST_BUSY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && status_o[BUSY_BIT]) |=> ($stable(data0_o) && $stable(status_o)
                                           && $stable(hard_req_o))); // R4
    AST_RELEASE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_i && status_o[BUSY_BIT]) |=> (!status_o[BUSY_BIT] && !hard_req_o
                                            && $stable(data0_o))); // R5
    AST_WAKE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |=> !wake_o); // R6
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_i && !status_o[BUSY_BIT]) |=> (!hard_req_o && !wake_o
                                             && $stable(data0_o))); // R7

endmodule

// File: tb/sim_ivec_latch.sv
module sim_ivec_latch;

    localparam int CLK_PERIOD = 10;

    typedef struct {
        string       tag;
        logic [7:0]  status;
        logic [63:0] d0;
        logic [63:0] d1;
        logic [63:0] d2;
        logic [8:0]  trap;
        logic        hard;
        logic        wake;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [5:0]  vec = '0;
    logic [7:0]  status;
    logic [63:0] d0, d1, d2;
    logic [8:0]  trap;
    logic        hard, wake;

    int checks = 0;
    int errors = 0;
    exp_t q[$];

    logic        m_busy = 0, m_hard = 0;
    logic [8:0]  m_trap = '0;
    logic [63:0] m_d0 = '0;
    bit          done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ivec_latch u0 (
        .clk(clk), .rst_n(rst_n), .req_i(req), .vec_i(vec),
        .status_o(status), .data0_o(d0), .data1_o(d1), .data2_o(d2),
        .trap_idx_o(trap), .hard_req_o(hard), .wake_o(wake)
    );

    task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic cmp(exp_t e);
        chk(e.tag, "status", 64'(status), 64'(e.status));
        chk(e.tag, "data0",  d0, e.d0);
        chk(e.tag, "data1",  d1, e.d1);
        chk(e.tag, "data2",  d2, e.d2);
        chk(e.tag, "trap",   64'(trap), 64'(e.trap));
        chk(e.tag, "hard",   64'(hard), 64'(e.hard));
        chk(e.tag, "wake",   64'(wake), 64'(e.wake));
    endtask

    // driver: drive at negedge, model the expected outputs, push to scoreboard
    task automatic step(logic r, logic [5:0] v, string tag);
        exp_t e;
        logic w;
        @(negedge clk);
        req = r;
        vec = v;
        w = 1'b0;
        if (r && !m_busy) begin
            m_busy = 1; m_hard = 1; w = 1;
            m_trap = 9'h060;
            m_d0 = 64'h7C0 | 64'(v);
        end else if (!r && m_busy) begin
            m_busy = 0; m_hard = 0;
        end
        e.tag = tag;
        e.status = {2'b00, m_busy, 5'b00000};
        e.d0 = m_d0; e.d1 = '0; e.d2 = '0;
        e.trap = m_trap; e.hard = m_hard; e.wake = w;
        q.push_back(e);
    endtask

    // monitor: after each rising edge, compare against the oldest expectation
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) cmp(q.pop_front());
        end
    end

    initial begin
        exp_t r;
        repeat (3) @(negedge clk);
        r.tag = "R1"; r.status = '0; r.d0 = '0; r.d1 = '0; r.d2 = '0;
        r.trap = '0; r.hard = 0; r.wake = 0;
        cmp(r);
        rst_n = 1'b1;
        step(0, 6'h00, "R7");           // idle low request: nothing moves
        step(1, 6'h15, "R2");           // capture, sets busy, trap, wake (R3, R6)
        step(1, 6'h15, "R6");           // held high: wake must be gone
        step(1, 6'h2A, "R4");           // new vector while busy is dropped
        step(1, 6'h3F, "R4");
        step(0, 6'h3F, "R5");           // release keeps data and trap
        step(0, 6'h01, "R7");
        step(1, 6'h3F, "R8");           // re-capture with new vector
        step(0, 6'h00, "R5");
        step(1, 6'h00, "R3");           // vector zero -> data0 = 0x7C0
        step(1, 6'h11, "R4");
        step(0, 6'h11, "R5");
        step(1, 6'h0A, "R8");
        step(0, 6'h0A, "R5");
        repeat (3) @(negedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule